// File: doc/BRIEF.md
# Dual-Channel Converter Output Sequencer

This block is the digital back end of a converter that samples two inputs at the same instant. Each cycle of `clk` is one conversion period. On every edge the block accepts one conversion and shows its result on the output exactly five cycles later. The analog front end sits outside the block and supplies one 12-bit raw straight-binary word for each input, `samp_a` and `samp_b`.

In single-input mode every slot converts the selected input. In two-input mode a slot captures both words at once and emits the input A result. The input B word waits in a hold register and goes out in the next slot, so each input runs at half rate. An active-low marker identifies input A results in two-input mode. Three further functions act at the moment a conversion is taken:
- fixed test codes can replace the samples, so the bus wiring can be checked;
- a measured offset can be removed, with saturation;
- the result can be written as straight binary or as two's complement.

A change of input selection empties the delay line. The outputs stay invalid until new conversions reach the end of it.

Top module: `adc_out_sequencer`

## Requirements
- R1: The conversion taken at clock edge k appears on `res_data`/`res_chan`/`res_valid` right after edge k+5.
- R2: With `cfg_two_ch`=0, every slot converts one input: A when `cfg_sel_b`=0, B when `cfg_sel_b`=1. `res_chan` gives the input (0=A, 1=B), and `sync_n` stays high.
- R3: With `cfg_two_ch`=1, slots alternate between a pair slot and a hold slot. A pair slot captures both `samp_a` and `samp_b` and yields the A result. The hold slot that follows yields the B result of that same pair. Sample inputs presented during a hold slot are ignored.
- R4: `sync_n` is low exactly while a valid input-A result of two-input mode is on the output, and high at all other times.
- R5: With `cfg_binary`=1 the result is straight binary. With `cfg_binary`=0 the result is two's complement, formed by inverting bit 11. The mapping is 000h→800h, 800h→000h and FFFh→7FFh.
- R6: `cfg_test` substitutes a fixed value for the sample: 01 gives 000h, 10 gives 800h and 11 gives FFFh, in binary before formatting. No offset is applied to these values. 00 selects the sampled words.
- R7: A rising edge of `cfg_offset_en` turns that slot's conversion into an offset measurement. The offset stored is the slot's live word minus 800h. That slot yields no valid result, and if it is a pair slot the following hold slot yields none either.
- R8: While `cfg_offset_en`=1, the stored offset is subtracted from every later conversion. The difference is clamped to 000h..FFFh before formatting. While `cfg_offset_en`=0, no correction is made.
- R9: A change of `cfg_two_ch` or `cfg_sel_b` discards every conversion in flight. The conversion taken on the edge of the change starts at a pair slot, and it is the first valid result, five cycles later.
- R10: During and right after reset, `res_valid`=0, `res_data`=000h and `sync_n`=1, and the stored offset is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; one conversion slot per edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_two_ch | input | 1 | 1 = two-input interleaved mode |
| cfg_sel_b | input | 1 | Single-input mode: 0 = input A, 1 = input B |
| cfg_binary | input | 1 | 1 = straight binary, 0 = two's complement |
| cfg_offset_en | input | 1 | Offset correction enable; its rising edge starts a measurement |
| cfg_test | input | 2 | Test code select (00 = normal) |
| samp_a | input | 12 | Raw word of input A |
| samp_b | input | 12 | Raw word of input B |
| res_data | output | 12 | Formatted result |
| res_chan | output | 1 | Input of the result (0 = A, 1 = B) |
| res_valid | output | 1 | Result is valid |
| sync_n | output | 1 | Low while an input-A result of two-input mode is shown |

## Verification
The assertions check these structural rules on every cycle:
- every valid delay stage comes from a valid stage one cycle earlier;
- a flush leaves the output invalid;
- a measurement slot never produces a result;
- `sync_n` is never low on two cycles in a row;
- a pair result is always followed by the B slot of the same pair;
- single-input results never switch input without a gap.

Only the bench scenarios show the actual values. These are the exact five-cycle alignment, the formatted codes, the test substitutions, the saturated offset arithmetic and the dropping of hold-slot inputs.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int unsigned DATA_W = 12;

    typedef logic [DATA_W-1:0]      word_t;
    typedef logic signed [DATA_W:0] offs_t;

    typedef enum logic { CH_A = 1'b0, CH_B = 1'b1 } chan_e;

    typedef enum logic [1:0] {
        TST_OFF  = 2'b00,
        TST_LOW  = 2'b01,
        TST_MID  = 2'b10,
        TST_HIGH = 2'b11
    } test_e;

    typedef struct packed {
        logic  valid;
        logic  pair;
        chan_e chan;
        word_t data;
    } res_item_t;

    localparam word_t MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    function automatic word_t test_word(input test_e t);
        case (t)
            TST_LOW:  return '0;
            TST_MID:  return MID_CODE;
            TST_HIGH: return '1;
            default:  return '0;
        endcase
    endfunction

    function automatic word_t sat_sub(input word_t w, input offs_t off);
        logic signed [DATA_W+1:0] diff;
        diff = $signed({2'b00, w}) - $signed({off[DATA_W], off});
        if (diff < 0)
            return '0;
        else if (diff > $signed({2'b00, {DATA_W{1'b1}}}))
            return '1;
        else
            return diff[DATA_W-1:0];
    endfunction

    function automatic word_t to_output(input word_t w, input logic binary);
        return binary ? w : {~w[DATA_W-1], w[DATA_W-2:0]};
    endfunction

    function automatic offs_t offset_of(input word_t w);
        return $signed({1'b0, w}) - $signed({1'b0, MID_CODE});
    endfunction

endpackage

// File: rtl/adc_seq_capture.sv
module adc_seq_capture
    import adc_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      two_ch,
    input  logic      sel_b,
    input  logic      binary,
    input  logic      offset_en,
    input  test_e     test_sel,
    input  word_t     samp_a,
    input  word_t     samp_b,
    output res_item_t s0,
    output logic      flush
);

    logic [1:0] mode_now, mode_q;
    logic       phase_q, phase_eff;
    logic       hold_slot, pair_slot;
    logic       hold_vld_q, off_en_q, cal;
    word_t      hold_q, live_word, slot_word, corrected;
    offs_t      off_q;
    chan_e      slot_chan;
    logic       slot_valid;

    always_comb begin
        mode_now   = {two_ch, sel_b};
        flush      = (mode_now != mode_q);
        phase_eff  = flush ? 1'b0 : phase_q;
        hold_slot  = two_ch & phase_eff;
        pair_slot  = two_ch & ~phase_eff;
        if (two_ch)
            slot_chan = phase_eff ? CH_B : CH_A;
        else
            slot_chan = sel_b ? CH_B : CH_A;
        live_word  = (slot_chan == CH_B) ? samp_b : samp_a;
        slot_word  = hold_slot ? hold_q : live_word;
        slot_valid = hold_slot ? hold_vld_q : 1'b1;
        cal        = offset_en & ~off_en_q;
        if (test_sel != TST_OFF)
            corrected = test_word(test_sel);
        else if (offset_en)
            corrected = sat_sub(slot_word, off_q);
        else
            corrected = slot_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= mode_now;
            phase_q    <= 1'b0;
            hold_q     <= '0;
            hold_vld_q <= 1'b0;
            off_en_q   <= 1'b0;
            off_q      <= '0;
            s0         <= '0;
        end else begin
            mode_q   <= mode_now;
            off_en_q <= offset_en;
            phase_q  <= pair_slot;
            if (pair_slot) begin
                hold_q     <= samp_b;
                hold_vld_q <= ~cal;
            end
            if (cal)
                off_q <= offset_of(live_word);
            s0.valid <= slot_valid & ~cal;
            s0.pair  <= two_ch;
            s0.chan  <= slot_chan;
            s0.data  <= to_output(corrected, binary);
        end
    end

    // R7: a measurement slot never yields a result
    a_r7_cal_consumes: assert property (@(posedge clk) disable iff (rst)
        cal |=> !s0.valid);

    // R3: a pair slot is always followed by a hold slot unless the mode changes
    a_r3_pair_then_hold: assert property (@(posedge clk) disable iff (rst)
        (two_ch && !flush && !phase_q) |=> (phase_q || flush));

endmodule

// File: rtl/adc_seq_delay.sv
module adc_seq_delay
    import adc_seq_pkg::*;
#(
    parameter int unsigned DEPTH = 5
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  res_item_t in_item,
    output res_item_t out_item
);

    res_item_t stage_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < DEPTH; i++)
                stage_q[i] <= '0;
        end else begin
            stage_q[0] <= in_item;
            for (int i = 1; i < DEPTH; i++)
                stage_q[i] <= stage_q[i-1];
        end
    end

    assign out_item = stage_q[DEPTH-1];

    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
        if (g == 0) begin : g_first
            // R1: a valid entry comes from a valid conversion one cycle before
            a_r1_valid_has_source: assert property (@(posedge clk) disable iff (rst)
                stage_q[0].valid |-> $past(in_item.valid));
        end else begin : g_rest
            // R1: validity only moves one stage per cycle
            a_r1_valid_has_source: assert property (@(posedge clk) disable iff (rst)
                stage_q[g].valid |-> $past(stage_q[g-1].valid));
        end
    end

    // R9: a flush leaves nothing valid at the output
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> !out_item.valid);

endmodule

// File: rtl/adc_out_sequencer.sv
module adc_out_sequencer
    import adc_seq_pkg::*;
#(
    parameter int unsigned LATENCY = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_two_ch,
    input  logic              cfg_sel_b,
    input  logic              cfg_binary,
    input  logic              cfg_offset_en,
    input  logic [1:0]        cfg_test,
    input  logic [DATA_W-1:0] samp_a,
    input  logic [DATA_W-1:0] samp_b,
    output logic [DATA_W-1:0] res_data,
    output logic              res_chan,
    output logic              res_valid,
    output logic              sync_n
);

    localparam int unsigned DELAY_STAGES = LATENCY;

    res_item_t s0_item, out_item;
    logic      flush;

    adc_seq_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .two_ch    (cfg_two_ch),
        .sel_b     (cfg_sel_b),
        .binary    (cfg_binary),
        .offset_en (cfg_offset_en),
        .test_sel  (test_e'(cfg_test)),
        .samp_a    (samp_a),
        .samp_b    (samp_b),
        .s0        (s0_item),
        .flush     (flush)
    );

    adc_seq_delay #(.DEPTH(DELAY_STAGES)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .in_item  (s0_item),
        .out_item (out_item)
    );

    assign res_data  = out_item.data;
    assign res_chan  = out_item.chan;
    assign res_valid = out_item.valid;
    assign sync_n    = ~(out_item.valid & out_item.pair & (out_item.chan == CH_A));

    // R4: the input-A marker never lasts two cycles
    a_r4_sync_alternates: assert property (@(posedge clk) disable iff (rst)
        !sync_n |=> sync_n);

    // R3: an input-A pair result is followed by the B result of the same pair
    a_r3_b_follows_a: assert property (@(posedge clk) disable iff (rst)
        (res_valid && out_item.pair && out_item.chan == CH_A && !flush)
            |=> (out_item.chan == CH_B && out_item.pair));

    // R2: back-to-back single-input results share one input
    a_r2_single_chan_steady: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !out_item.pair && $past(res_valid) && !$past(out_item.pair))
            |-> (res_chan == $past(res_chan)));

endmodule

// File: tb/adc_out_sequencer_tb.sv
module adc_out_sequencer_tb;

    localparam int LAT = 5;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_two_ch, cfg_sel_b, cfg_binary, cfg_offset_en;
    logic [1:0]  cfg_test;
    logic [11:0] samp_a, samp_b;
    logic [11:0] res_data;
    logic        res_chan, res_valid, sync_n;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    adc_out_sequencer u_dut (
        .clk           (clk),
        .rst           (rst),
        .cfg_two_ch    (cfg_two_ch),
        .cfg_sel_b     (cfg_sel_b),
        .cfg_binary    (cfg_binary),
        .cfg_offset_en (cfg_offset_en),
        .cfg_test      (cfg_test),
        .samp_a        (samp_a),
        .samp_b        (samp_b),
        .res_data      (res_data),
        .res_chan      (res_chan),
        .res_valid     (res_valid),
        .sync_n        (sync_n)
    );

    typedef struct {
        bit          valid;
        bit          chan;
        bit          pair;
        logic [11:0] data;
        string       req;
    } exp_t;

    exp_t q[$];

    // independent reference state
    bit [1:0]    m_mode;
    bit          m_phase, m_hold_vld, m_offen;
    logic [11:0] m_hold;
    int          m_off;

    task automatic check_out(input exp_t e);
        bit exp_sync;
        checks++;
        exp_sync = !(e.valid && e.pair && !e.chan);
        if (e.valid) begin
            if (!(res_valid === 1'b1 && res_data === e.data && res_chan === e.chan
                  && sync_n === exp_sync)) begin
                errors++;
                $display("FAIL %s: got valid=%0b data=%03h ch=%0b sync_n=%0b, expected valid=1 data=%03h ch=%0b sync_n=%0b",
                         e.req, res_valid, res_data, res_chan, sync_n, e.data, e.chan, exp_sync);
            end
        end else begin
            if (!(res_valid === 1'b0 && sync_n === 1'b1)) begin
                errors++;
                $display("FAIL %s: got valid=%0b sync_n=%0b, expected valid=0 sync_n=1",
                         e.req, res_valid, sync_n);
            end
        end
    endtask

    task automatic step(input logic [11:0] a, input logic [11:0] b, input string req);
        bit          flush, phase_eff, hold_slot, pair_slot, chan, vld, cal;
        logic [11:0] live, word, data;
        int          v;
        exp_t        e;
        samp_a = a;
        samp_b = b;
        flush     = ({cfg_two_ch, cfg_sel_b} != m_mode);
        phase_eff = flush ? 1'b0 : m_phase;
        hold_slot = cfg_two_ch && phase_eff;
        pair_slot = cfg_two_ch && !phase_eff;
        chan      = cfg_two_ch ? phase_eff : cfg_sel_b;
        live      = chan ? b : a;
        word      = hold_slot ? m_hold : live;
        vld       = hold_slot ? m_hold_vld : 1'b1;
        cal       = cfg_offset_en && !m_offen;
        if (cfg_test != 2'b00)
            v = (cfg_test == 2'b01) ? 0 : (cfg_test == 2'b10) ? 2048 : 4095;
        else if (cfg_offset_en) begin
            v = int'(word) - m_off;
            if (v < 0) v = 0;
            if (v > 4095) v = 4095;
        end else
            v = int'(word);
        data = 12'(v);
        if (!cfg_binary) data = data ^ 12'h800;
        if (flush)
            foreach (q[i]) begin
                q[i].valid = 1'b0;
                q[i].req   = "R9";
            end
        e.valid = vld && !cal;
        e.chan  = chan;
        e.pair  = cfg_two_ch;
        e.data  = data;
        e.req   = req;
        q.push_back(e);
        m_mode  = {cfg_two_ch, cfg_sel_b};
        m_offen = cfg_offset_en;
        m_phase = pair_slot;
        if (pair_slot) begin
            m_hold     = b;
            m_hold_vld = !cal;
        end
        if (cal) m_off = int'(live) - 2048;
        @(posedge clk);
        #1;
        if (q.size() > LAT) check_out(q.pop_front());
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cfg_two_ch = 0; cfg_sel_b = 0; cfg_binary = 1; cfg_offset_en = 0; cfg_test = 2'b00;
        samp_a = '0; samp_b = '0;
        m_mode = 2'b00; m_phase = 0; m_hold_vld = 0; m_offen = 0; m_hold = '0; m_off = 0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R10: outputs after reset
        checks++;
        if (!(res_valid === 1'b0 && res_data === 12'h000 && sync_n === 1'b1)) begin
            errors++;
            $display("FAIL R10: got valid=%0b data=%03h sync_n=%0b, expected 0 000 1",
                     res_valid, res_data, sync_n);
        end

        // R1 R2: single input A, every slot used
        for (int i = 0; i < 8; i++)
            step(12'(i * 12'h111 + 3), 12'hABC, "R1 R2 input A");
        // R2 R9: switch to input B
        cfg_sel_b = 1;
        for (int i = 0; i < 8; i++)
            step(12'h5A5, 12'(12'hF00 - i * 12'h0F1), "R2 input B");

        // R3 R4: two-input interleave, hold-slot inputs differ and must be dropped
        cfg_two_ch = 1;
        for (int i = 0; i < 10; i++)
            step(12'(12'h100 + i * 12'h013), 12'(12'hE00 - i * 12'h021), "R3 R4 interleave");

        // R5: two's complement codes at min, mid and full scale
        cfg_binary = 0;
        step(12'h000, 12'hFFF, "R5 twos");
        step(12'h333, 12'h444, "R5 twos");
        step(12'h800, 12'h800, "R5 twos");
        step(12'h222, 12'h111, "R5 twos");
        step(12'hFFF, 12'h000, "R5 twos");
        step(12'h999, 12'h888, "R5 twos");

        // R6: test code substitution in both formats
        for (int t = 1; t < 4; t++) begin
            cfg_test = 2'(t);
            cfg_binary = 1;
            step(12'h123, 12'h456, "R6 test binary");
            step(12'h789, 12'hABC, "R6 test binary");
            cfg_binary = 0;
            step(12'h321, 12'h654, "R6 test twos");
            step(12'h987, 12'hCBA, "R6 test twos");
        end
        cfg_test = 2'b00;
        cfg_binary = 1;

        // R7 R8: offset measurement and saturating correction, single input
        cfg_two_ch = 0; cfg_sel_b = 0;
        step(12'h400, 12'h000, "R9 mode back");
        cfg_offset_en = 1;
        step(12'h810, 12'h000, "R7 measure +16");
        step(12'h005, 12'h000, "R8 clamp low");
        step(12'h900, 12'h000, "R8 subtract");
        step(12'hFFF, 12'h000, "R8 subtract top");
        cfg_offset_en = 0;
        step(12'h005, 12'h000, "R8 disabled");
        cfg_offset_en = 1;
        step(12'h7F0, 12'h000, "R7 measure -16");
        step(12'hFFA, 12'h000, "R8 clamp high");
        step(12'h000, 12'h000, "R8 add");
        cfg_binary = 0;
        step(12'h80A, 12'h000, "R8 R5 twos corrected");
        cfg_binary = 1;
        cfg_offset_en = 0;

        // R7: measurement on a pair slot consumes both results
        cfg_two_ch = 1;
        step(12'h210, 12'h620, "R3 pair");
        step(12'h000, 12'h000, "R3 hold");
        cfg_offset_en = 1;
        step(12'h820, 12'h7E0, "R7 pair measure");
        step(12'h111, 12'h111, "R7 hold consumed");
        step(12'h300, 12'h030, "R8 pair corrected");
        step(12'h000, 12'h000, "R8 hold corrected");
        cfg_offset_en = 0;

        // R9: mode change mid-stream empties the line
        step(12'h444, 12'h555, "R3 pair");
        cfg_two_ch = 0; cfg_sel_b = 1;
        for (int i = 0; i < 7; i++)
            step(12'h0F0, 12'(12'h0A0 + i), "R9 after switch");

        // drain
        for (int i = 0; i < LAT + 1; i++)
            step(12'h000, 12'h001, "R1 drain");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule